// File: doc/BRIEF.md
# Interrupt priority register array with secure view

This block holds one 8-bit priority for every interrupt ID and lets software reach them through byte or word accesses. A word access covers four consecutive IDs. Every request carries a secure/non-secure attribute. An external single-security-state bit (`ds_i`) and a per-interrupt group vector (`grp_i`) decide how a non-secure request sees each entry. When the two security states are separate, non-secure software only reaches entries whose group bit is 1. It sees such an entry through a halved view: it reads the value shifted left by one, and anything it writes lands in the upper half of the priority range.

Requests use a valid/ready handshake. Read data returns registered, one cycle after the request is accepted. Each write that passes the range check pulses an update output that names the first affected ID and the number of entries covered, so that downstream priority logic can re-evaluate them. Priority arbitration is not part of this block.

Top module: `prio_regs`

## Requirements
- R1: After reset every stored priority is 0, `rsp_valid_o` and `upd_valid_o` are low, and `req_ready_o` is high from the first clock edge after reset onward.
- R2: A word access ignores `req_addr_i[1:0]` and covers IDs base..base+3, where base is the address with its two low bits cleared. ID base+k sits in data bits [8k+7:8k]. A byte access at address n addresses ID n in bits [7:0], and a byte read returns 0 in bits [31:8].
- R3: A secure access (`req_secure_i`=1), or any access while `ds_i`=1, reads and writes the stored byte unchanged.
- R4: A non-secure read (`req_secure_i`=0, `ds_i`=0) of an entry whose `grp_i` bit is 1 returns (stored << 1) truncated to 8 bits.
- R5: A non-secure write (`req_secure_i`=0, `ds_i`=0) to an entry whose `grp_i` bit is 1 stores 0x80 | (value >> 1).
- R6: A non-secure access with `ds_i`=0 to an entry whose `grp_i` bit is 0 reads 0 and leaves the entry unchanged.
- R7: IDs below 32 and IDs at or above NUM_IRQ read 0 and ignore writes.
- R8: A word write is dropped as a whole when its base is below 32 or base+3 is not below NUM_IRQ, even if some of its IDs are implemented. A byte write is range-checked only for its own ID.
- R9: `rsp_valid_o` is high exactly in the cycle after an accepted read and carries that read's data in `rsp_rdata_o`.
- R10: In the cycle after an accepted write that passes the range check of R7/R8, `upd_valid_o` pulses with `upd_id_o` = first ID and `upd_cnt_o` = 4 for a word or 1 for a byte. This happens even when the security rules block some or all of the entries. No other cycle pulses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ds_i | input | 1 | Single security state: 1 gives non-secure requests the secure view |
| grp_i | input | NUM_IRQ | Group bit per ID; 1 makes the entry visible to non-secure requests |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_write_i | input | 1 | 1 write, 0 read |
| req_word_i | input | 1 | 1 word (four IDs), 0 byte (one ID) |
| req_secure_i | input | 1 | Request is secure |
| req_addr_i | input | ADDR_W | Byte offset, equal to the interrupt ID for byte accesses |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| upd_valid_o | output | 1 | Update pulse |
| upd_id_o | output | ADDR_W | First ID touched by the write |
| upd_cnt_o | output | 3 | Number of IDs covered by the write (1 or 4) |

## Verification
The bench builds the block with NUM_IRQ=42 and ADDR_W=8. Because the count is not a multiple of four, the last word (IDs 40..43) is only partly implemented. That case shows a word write dropped as a whole while byte writes to IDs 40 and 41 still land and ID 42 is refused. The 8-bit address keeps random addresses in a small window that takes in the reserved IDs below 32, every implemented ID and the IDs past the end. The random accesses mix in changes of `ds_i` and of the group bits.

// File: rtl/prio_pkg.sv
package prio_pkg;
  localparam int PRIO_W   = 8;
  localparam int LANES    = 4;
  localparam int DATA_W   = PRIO_W * LANES;
  localparam int FIRST_ID = 32;

  // non-secure read view: priority doubled, top bit lost
  function automatic logic [PRIO_W-1:0] ns_rd_view(input logic [PRIO_W-1:0] v);
    return {v[PRIO_W-2:0], 1'b0};
  endfunction

  // non-secure write view: forced into upper half of the range
  function automatic logic [PRIO_W-1:0] ns_wr_view(input logic [PRIO_W-1:0] v);
    return {1'b1, v[PRIO_W-1:1]};
  endfunction
endpackage

// File: rtl/prio_lane.sv
module prio_lane
  import prio_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int ADDR_W  = 10
) (
  input  logic [ADDR_W-1:0]  id_i,
  input  logic               active_i,
  input  logic               ns_view_i,
  input  logic [NUM_IRQ-1:0] grp_i,
  input  logic [PRIO_W-1:0]  stored_i,
  input  logic [PRIO_W-1:0]  wbyte_i,
  output logic               allowed_o,
  output logic [PRIO_W-1:0]  rd_o,
  output logic [PRIO_W-1:0]  wr_o
);
  logic impl, grp_bit;

  always_comb begin
    grp_bit = 1'b0;
    for (int e = 0; e < NUM_IRQ; e++)
      if (id_i == ADDR_W'(e)) grp_bit = grp_i[e];
  end

  assign impl      = (32'(id_i) >= FIRST_ID) && (32'(id_i) < NUM_IRQ);
  assign allowed_o = active_i && impl && (!ns_view_i || grp_bit);
  assign rd_o      = !allowed_o ? '0 : (ns_view_i ? ns_rd_view(stored_i) : stored_i);
  assign wr_o      = ns_view_i ? ns_wr_view(wbyte_i) : wbyte_i;
endmodule

// File: rtl/prio_store.sv
module prio_store
  import prio_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int ADDR_W  = 10
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [LANES-1:0]                   we_i,
  input  logic [LANES-1:0][ADDR_W-1:0]       id_i,
  input  logic [LANES-1:0][PRIO_W-1:0]       wdata_i,
  output logic [LANES-1:0][PRIO_W-1:0]       rdata_o
);
  logic [PRIO_W-1:0] mem_q [NUM_IRQ];

  for (genvar e = 0; e < NUM_IRQ; e++) begin : g_ent
    if (e < FIRST_ID) begin : g_rsvd
      assign mem_q[e] = '0;
    end else begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mem_q[e] <= '0;
        else begin
          for (int l = 0; l < LANES; l++)
            if (we_i[l] && id_i[l] == ADDR_W'(e)) mem_q[e] <= wdata_i[l];
        end
      end
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      rdata_o[l] = '0;
      for (int e = 0; e < NUM_IRQ; e++)
        if (id_i[l] == ADDR_W'(e)) rdata_o[l] = mem_q[e];
    end
  end
endmodule

// File: rtl/prio_regs.sv
module prio_regs
  import prio_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int ADDR_W  = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ds_i,
  input  logic [NUM_IRQ-1:0] grp_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_write_i,
  input  logic               req_word_i,
  input  logic               req_secure_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [31:0]        req_wdata_i,
  output logic               rsp_valid_o,
  output logic [31:0]        rsp_rdata_o,
  output logic               upd_valid_o,
  output logic [ADDR_W-1:0]  upd_id_o,
  output logic [2:0]         upd_cnt_o
);
  logic                         rdy_q, accept, ns_view, range_ok, word_ok, byte_ok;
  logic [ADDR_W-1:0]            base;
  logic [LANES-1:0]             active, allowed, we;
  logic [LANES-1:0][ADDR_W-1:0] lane_id;
  logic [LANES-1:0][PRIO_W-1:0] stored, rd_lane, wr_lane;

  assign req_ready_o = rdy_q;
  assign accept      = req_valid_i && rdy_q;
  assign ns_view     = !req_secure_i && !ds_i;
  assign base        = req_word_i ? {req_addr_i[ADDR_W-1:2], 2'b00} : req_addr_i;
  assign word_ok     = (32'(base) >= FIRST_ID) && (32'(base) + LANES - 1 < NUM_IRQ);
  assign byte_ok     = (32'(base) >= FIRST_ID) && (32'(base) < NUM_IRQ);
  assign range_ok    = req_word_i ? word_ok : byte_ok;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_id[k] = base + ADDR_W'(k);
    assign active[k]  = req_word_i || (k == 0);
    assign we[k]      = accept && req_write_i && range_ok && allowed[k];

    prio_lane #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_lane (
      .id_i      (lane_id[k]),
      .active_i  (active[k]),
      .ns_view_i (ns_view),
      .grp_i     (grp_i),
      .stored_i  (stored[k]),
      .wbyte_i   (req_wdata_i[PRIO_W*k +: PRIO_W]),
      .allowed_o (allowed[k]),
      .rd_o      (rd_lane[k]),
      .wr_o      (wr_lane[k])
    );
  end

  prio_store #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .id_i    (lane_id),
    .wdata_i (wr_lane),
    .rdata_o (stored)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q       <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      upd_valid_o <= 1'b0;
      upd_id_o    <= '0;
      upd_cnt_o   <= '0;
    end else begin
      rdy_q       <= 1'b1;
      rsp_valid_o <= accept && !req_write_i;
      if (accept && !req_write_i) rsp_rdata_o <= rd_lane;
      upd_valid_o <= accept && req_write_i && range_ok;
      if (accept && req_write_i) begin
        upd_id_o  <= base;
        upd_cnt_o <= req_word_i ? 3'(LANES) : 3'd1;
      end
    end
  end
endmodule

// File: rtl/prio_regs_chk.sv
module prio_regs_chk #(
  parameter int NUM_IRQ = 64,
  parameter int ADDR_W  = 10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ds_i,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic               req_write_i,
  input logic               req_word_i,
  input logic               req_secure_i,
  input logic               rsp_valid_o,
  input logic [31:0]        rsp_rdata_o,
  input logic               upd_valid_o,
  input logic [ADDR_W-1:0]  upd_id_o,
  input logic [2:0]         upd_cnt_o
);
  assert_rsp_follows_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !req_write_i) |=> rsp_valid_o);

  assert_rsp_only_after_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_valid_i && req_ready_o && !req_write_i));

  assert_byte_read_narrow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && $past(!req_word_i)) |-> (rsp_rdata_o[31:8] == 24'd0));

  assert_ns_view_even_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && $past(!req_secure_i && !ds_i)) |->
    (!rsp_rdata_o[0] && !rsp_rdata_o[8] && !rsp_rdata_o[16] && !rsp_rdata_o[24]));

  assert_upd_after_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |-> $past(req_valid_i && req_ready_o && req_write_i));

  assert_upd_count_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |-> (upd_cnt_o == 3'd1 || (upd_cnt_o == 3'd4 && upd_id_o[1:0] == 2'b00)));

  assert_upd_in_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |-> (32'(upd_id_o) >= 32 && 32'(upd_id_o) + 32'(upd_cnt_o) <= NUM_IRQ));
endmodule

bind prio_regs prio_regs_chk #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ds_i         (ds_i),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_write_i  (req_write_i),
  .req_word_i   (req_word_i),
  .req_secure_i (req_secure_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_rdata_o  (rsp_rdata_o),
  .upd_valid_o  (upd_valid_o),
  .upd_id_o     (upd_id_o),
  .upd_cnt_o    (upd_cnt_o)
);

// File: tb/prio_regs_tb.sv
module prio_regs_tb;
  localparam int NUM = 42;
  localparam int AW  = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ds = 1'b0;
  logic [NUM-1:0]  grp = '0;
  logic            valid = 1'b0, wr = 1'b0, word = 1'b0, sec = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [31:0]     wdata = '0;
  logic            ready, rvalid, uvalid;
  logic [31:0]     rdata;
  logic [AW-1:0]   uid;
  logic [2:0]      ucnt;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mdl [256];

  always #5 clk = ~clk;

  prio_regs #(.NUM_IRQ(NUM), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ds_i(ds), .grp_i(grp),
    .req_valid_i(valid), .req_ready_o(ready), .req_write_i(wr), .req_word_i(word),
    .req_secure_i(sec), .req_addr_i(addr), .req_wdata_i(wdata),
    .rsp_valid_o(rvalid), .rsp_rdata_o(rdata),
    .upd_valid_o(uvalid), .upd_id_o(uid), .upd_cnt_o(ucnt)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit impl(input int id);
    return id >= 32 && id < NUM;
  endfunction

  function automatic bit permit(input int id, input bit s);
    return impl(id) && (s || ds || grp[id]);
  endfunction

  function automatic logic [7:0] exp_byte(input int id, input bit s);
    if (!permit(id, s)) return 8'h00;
    return (!s && !ds) ? {mdl[id][6:0], 1'b0} : mdl[id];
  endfunction

  function automatic logic [31:0] exp_read(input bit w, input bit s, input int a);
    logic [31:0] r = '0;
    if (!w) return {24'd0, exp_byte(a, s)};
    for (int k = 0; k < 4; k++) r[8*k +: 8] = exp_byte((a & ~3) + k, s);
    return r;
  endfunction

  task automatic access(input bit w_en, input bit w, input bit s, input int a,
                        input logic [31:0] d, input string tag);
    logic [31:0] exp_rd;
    bit          exp_upd = 1'b0;
    int          base = w ? (a & ~3) : a;
    exp_rd = exp_read(w, s, a);
    if (w_en) begin
      exp_upd = w ? (base >= 32 && base + 3 < NUM) : impl(base);
      if (exp_upd)
        for (int k = 0; k < (w ? 4 : 1); k++)
          if (permit(base + k, s))
            mdl[base + k] = (!s && !ds) ? {1'b1, d[8*k+1 +: 7]} : d[8*k +: 8];
    end
    @(negedge clk);
    valid = 1'b1; wr = w_en; word = w; sec = s; addr = AW'(a); wdata = d;
    @(negedge clk);
    valid = 1'b0;
    if (w_en) begin
      check(uvalid == exp_upd && rvalid == 1'b0, {tag, " R10 upd pulse"}, {30'd0, rvalid, uvalid}, {31'd0, exp_upd});
      if (exp_upd)
        check(uid == AW'(base) && ucnt == (w ? 3'd4 : 3'd1), {tag, " R10 upd id/cnt"},
              {21'd0, ucnt, uid}, {21'd0, (w ? 3'd4 : 3'd1), AW'(base)});
    end else begin
      check(rvalid == 1'b1 && uvalid == 1'b0, {tag, " R9 rsp valid"}, {31'd0, rvalid}, 32'd1);
      check(rdata == exp_rd, {tag, " read data"}, rdata, exp_rd);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    #23 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rvalid == 1'b0 && uvalid == 1'b0 && ready == 1'b1, "R1 idle outputs",
          {29'd0, ready, rvalid, uvalid}, 32'h4);
    access(0, 1, 1, 36, 0, "R1 reset prio zero");
    // R2 R3 secure layout
    access(1, 1, 1, 32, 32'h44332211, "R3 secure word write");
    access(0, 1, 1, 32, 0, "R3 secure word read");
    access(0, 0, 1, 33, 0, "R2 byte read lane1");
    access(0, 1, 1, 35, 0, "R2 word ignores low addr bits");
    // R4 R5 non-secure view of group-1 entries
    grp[35:32] = 4'hF;
    access(0, 1, 0, 32, 0, "R4 ns shifted read");
    access(1, 0, 0, 34, 32'h40, "R5 ns byte write");
    access(0, 0, 1, 34, 0, "R5 stored 0x80|v>>1");
    // R6 hidden group-0 entries
    access(1, 1, 1, 36, 32'h5A5A5A5A, "R6 secure preset");
    grp[37] = 1'b1;
    access(1, 1, 0, 36, 32'hFFFFFFFF, "R6 ns word write mixed groups");
    access(0, 1, 1, 36, 0, "R6 secure readback");
    access(0, 0, 0, 36, 0, "R6 ns read hidden zero");
    // R3 single security state
    ds = 1'b1;
    access(1, 0, 0, 38, 32'h07, "R3 ds write raw");
    access(0, 1, 0, 36, 0, "R3 ds read raw");
    ds = 1'b0;
    // R7 R8 range edges
    access(1, 0, 1, 5, 32'hAA, "R7 byte write reserved id");
    access(0, 0, 1, 5, 0, "R7 reserved reads zero");
    access(1, 1, 1, 28, 32'h11111111, "R8 word below 32 dropped");
    access(1, 0, 1, 40, 32'h9C, "R8 byte 40 accepted");
    access(1, 0, 1, 41, 32'h9D, "R8 byte 41 accepted");
    access(1, 0, 1, 42, 32'h9E, "R7 byte 42 unimplemented");
    access(1, 1, 1, 40, 32'h01020304, "R8 partial word dropped");
    access(0, 1, 1, 40, 0, "R8 partial word read");
    access(0, 0, 1, 200, 0, "R7 far id reads zero");
    // random mix
    for (int i = 0; i < 400; i++) begin
      if (i % 40 == 0) begin
        grp = {$urandom, $urandom};
        ds  = ($urandom_range(0, 3) == 0);
      end
      access($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
             $urandom_range(0, 63), $urandom, "R2 R3 R4 R5 R6 random");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule